// File: doc/BRIEF.md
# Byte-Lane Write Enable Logic

This block sits between the control inputs of a wide synchronous memory and its array. On every rising clock edge it decides which 9-bit lanes of the incoming word are to be written. It registers that decision as one strobe per lane, and it registers the write word in the same edge, so that strobes and data reach the array together. It also raises a registered flag that tells the output stage to turn its drivers off whenever any lane is being written.

Write enables come in two levels. A global write enable, when low, writes every lane no matter what else is driven. Without it, per-lane selects can write individual lanes. These selects pass to the write stage only while a separate lane gate is low. With both the global enable and the gate high, the cycle is a read.

The lane count is a parameter: 4 lanes form a 36-bit word and 2 lanes form an 18-bit word. The input word packs all data bytes in its low bits and all parity bits above them. The registered output is regrouped lane by lane, each lane holding its own parity bit above its own byte.

Top module: `byte_lane_wr`

## Requirements
- R1: While `rst_n` is low at a rising edge, every lane strobe, the output-off flag and the whole registered word are zero after that edge, whatever the write inputs are.
- R2: When `all_wr_n` is low at a rising edge, every bit of `lane_wr_q` is 1 after that edge, regardless of `lane_gate_n` and `lane_sel_n`.
- R3: When `all_wr_n` is high and `lane_gate_n` is low at a rising edge, bit k of `lane_wr_q` after the edge equals the inverse of bit k of `lane_sel_n` sampled at that edge.
- R4: When `all_wr_n` and `lane_gate_n` are both high at a rising edge, `lane_wr_q` is all zero after that edge, even if every bit of `lane_sel_n` is low (the selects are ignored).
- R5: The word is captured at every rising edge out of reset, whatever the enables are. `wr_word` holds byte k in bits [8k+7:8k] and the parity bit of lane k in bit 8*LANES+k. In `lane_q`, lane k occupies bits [9k+8:9k], with its byte in the low 8 bits and its parity bit as bit 9k+8.
- R6: `out_off_q` is 1 in exactly those cycles in which at least one bit of `lane_wr_q` is 1.
- R7: The strobes and the registered word produced from one edge become visible in the same cycle, one cycle after the inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| all_wr_n | input | 1 | Global write enable, active low, writes all lanes |
| lane_gate_n | input | 1 | Lane gate, active low, lets the per-lane selects through |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| wr_word | input | 9*LANES | Write word: bytes in the low bits, parity bits above |
| lane_wr_q | output | LANES | Registered per-lane write strobes, active high |
| lane_q | output | 9*LANES | Registered write word regrouped by lane |
| out_off_q | output | 1 | Registered output-driver disable, high on write cycles |

## Verification
The bench drives the global enable low while the gate and the selects are at random values. A design that let the gate or the selects win over the global enable would then drop lanes. With the gate high and every select low, it expects no strobe and no output-off flag. A design that leaked the selects past a closed gate would write there. It checks the regrouped lanes against a bench-built packing of bytes and parity bits, which catches a lane or parity bit taken from the wrong position. A reset applied in the middle of a write catches registers that ignore reset.

// File: rtl/lane_wr_pkg.sv
// Package: shared widths and the lane type for the byte-lane write logic.
// Assumes every lane is one data byte plus one parity bit.
package lane_wr_pkg;
    localparam int BYTE_W = 8;
    localparam int LANE_W = BYTE_W + 1;

    typedef logic [LANE_W-1:0] lane_t;
endpackage

// File: rtl/lane_wr_decode.sv
// Module: lane_wr_decode
// Turns the two-level active-low enable set into one active-high enable per lane.
// The global enable overrides all other inputs. The selects count only while the gate is low.
// Assumes inputs are stable around the clock edge; purely combinational.
module lane_wr_decode #(
    parameter int LANES = 4
) (
    input  logic             all_wr_n,
    input  logic             lane_gate_n,
    input  logic [LANES-1:0] lane_sel_n,
    output logic [LANES-1:0] lane_en,
    output logic             any_en
);
    // Resolve the enable hierarchy lane by lane.
    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            if (!all_wr_n) begin
                lane_en[k] = 1'b1;
            end else if (!lane_gate_n) begin
                lane_en[k] = ~lane_sel_n[k];
            end else begin
                lane_en[k] = 1'b0;
            end
        end
    end

    // Flag a write cycle when any lane is enabled.
    always_comb begin
        any_en = |lane_en;
    end
endmodule

// File: rtl/lane_wr_slice.sv
// Module: lane_wr_slice
// Holds one lane: it registers that lane's strobe and its byte plus parity bit.
// The data loads on every edge out of reset. Only the strobe says whether the array writes.
// Assumes a synchronous active-low reset.
module lane_wr_slice
    import lane_wr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              par_i,
    output logic              strobe_q,
    output lane_t             lane_q
);
    // Register the strobe together with the lane data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            lane_q   <= '0;
        end else begin
            strobe_q <= en_i;
            lane_q   <= {par_i, byte_i};
        end
    end
endmodule

// File: rtl/byte_lane_wr.sv
// Module: byte_lane_wr (top)
// Decides which lanes are written on each edge. It registers the strobes, the word
// regrouped by lane, and a flag that turns the output drivers off.
// Assumes the input word carries the bytes in its low bits and the parity bits above them.
module byte_lane_wr
    import lane_wr_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    all_wr_n,
    input  logic                    lane_gate_n,
    input  logic [LANES-1:0]        lane_sel_n,
    input  logic [LANES*LANE_W-1:0] wr_word,
    output logic [LANES-1:0]        lane_wr_q,
    output logic [LANES*LANE_W-1:0] lane_q,
    output logic                    out_off_q
);
    localparam int PAR_BASE = LANES * BYTE_W;

    logic [LANES-1:0] lane_en;
    logic             any_en;

    lane_wr_decode #(.LANES(LANES)) u_dec (
        .all_wr_n    (all_wr_n),
        .lane_gate_n (lane_gate_n),
        .lane_sel_n  (lane_sel_n),
        .lane_en     (lane_en),
        .any_en      (any_en)
    );

    // One slice per lane; byte k and parity bit k form lane k.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        lane_t lane_w;
        lane_wr_slice u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_i     (lane_en[k]),
            .byte_i   (wr_word[k*BYTE_W +: BYTE_W]),
            .par_i    (wr_word[PAR_BASE + k]),
            .strobe_q (lane_wr_q[k]),
            .lane_q   (lane_w)
        );
        assign lane_q[k*LANE_W +: LANE_W] = lane_w;
    end

    // Register the output-driver disable in step with the strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_off_q <= 1'b0;
        end else begin
            out_off_q <= any_en;
        end
    end
endmodule

// File: rtl/byte_lane_wr_chk.sv
// Module: byte_lane_wr_chk
// Checker bound to byte_lane_wr. It relates the input enables to the strobes one edge later.
module byte_lane_wr_chk #(
    parameter int LANES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 all_wr_n,
    input logic                 lane_gate_n,
    input logic [LANES-1:0]     lane_sel_n,
    input logic [LANES*9-1:0]   wr_word,
    input logic [LANES-1:0]     lane_wr_q,
    input logic [LANES*9-1:0]   lane_q,
    input logic                 out_off_q
);
    // R2
    global_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !all_wr_n |=> (&lane_wr_q));

    // R3
    gated_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (all_wr_n && !lane_gate_n) |=> (lane_wr_q == ~$past(lane_sel_n)));

    // R4
    read_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (all_wr_n && lane_gate_n) |=> (lane_wr_q == '0));

    // R6
    out_off_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_off_q == (lane_wr_q != '0));

    // R5
    lane0_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lane_q[8:0] == {$past(wr_word[LANES*8]), $past(wr_word[7:0])}));
endmodule

bind byte_lane_wr byte_lane_wr_chk #(.LANES(LANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .all_wr_n    (all_wr_n),
    .lane_gate_n (lane_gate_n),
    .lane_sel_n  (lane_sel_n),
    .wr_word     (wr_word),
    .lane_wr_q   (lane_wr_q),
    .lane_q      (lane_q),
    .out_off_q   (out_off_q)
);

// File: tb/sim_byte_lane_wr.sv
// Bench for byte_lane_wr: directed corner cases plus seeded random cycles.
module sim_byte_lane_wr;
    localparam int CLK_P = 10;
    localparam int L     = 4;
    localparam int W     = L * 9;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         all_wr_n;
    logic         lane_gate_n;
    logic [L-1:0] lane_sel_n;
    logic [W-1:0] wr_word;
    logic [L-1:0] lane_wr_q;
    logic [W-1:0] lane_q;
    logic         out_off_q;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    byte_lane_wr #(.LANES(L)) u0 (
        .clk(clk), .rst_n(rst_n), .all_wr_n(all_wr_n), .lane_gate_n(lane_gate_n),
        .lane_sel_n(lane_sel_n), .wr_word(wr_word), .lane_wr_q(lane_wr_q),
        .lane_q(lane_q), .out_off_q(out_off_q)
    );

    always #(CLK_P/2) clk = ~clk;

    // Expected strobes from the enable hierarchy (R2, R3, R4).
    function automatic logic [L-1:0] exp_strobe(logic g_n, logic gate_n, logic [L-1:0] s_n);
        if (!g_n)         return '1;
        else if (!gate_n) return ~s_n;
        else              return '0;
    endfunction

    // Expected lane regrouping of the input word (R5).
    function automatic logic [W-1:0] exp_lanes(logic [W-1:0] w);
        logic [W-1:0] r;
        for (int k = 0; k < L; k++) begin
            r[k*9 +: 8] = w[k*8 +: 8];
            r[k*9 + 8]  = w[L*8 + k];
        end
        return r;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at the falling edge, let one rising edge capture, check at the next falling edge.
    task automatic cycle(logic r, logic g, logic gate, logic [L-1:0] s, logic [W-1:0] w);
        rst_n = r; all_wr_n = g; lane_gate_n = gate; lane_sel_n = s; wr_word = w;
        @(posedge clk);
        @(negedge clk);
        if (!r) begin
            check("R1 strobes", 64'(lane_wr_q), 64'd0);
            check("R1 off", 64'(out_off_q), 64'd0);
            check("R1 word", 64'(lane_q), 64'd0);
        end else begin
            check(!g ? "R2 strobes" : (!gate ? "R3 strobes" : "R4 strobes"),
                  64'(lane_wr_q), 64'(exp_strobe(g, gate, s)));
            check("R5/R7 word", 64'(lane_q), 64'(exp_lanes(w)));
            check("R6 off", 64'(out_off_q), 64'(exp_strobe(g, gate, s) != '0));
        end
    endtask

    initial begin
        @(negedge clk);
        cycle(1'b0, 1'b0, 1'b0, '0, '1);                 // R1 reset with a write asking
        cycle(1'b0, 1'b0, 1'b0, '0, '1);
        cycle(1'b1, 1'b0, 1'b1, '1, 36'h1_2345_6789);    // R2 global with gate closed
        cycle(1'b1, 1'b0, 1'b0, 4'b1010, 36'hA_0F0F_F0F0); // R2 overrides selects
        cycle(1'b1, 1'b1, 1'b0, 4'b0110, 36'h5_DEAD_BEEF); // R3 gated selects
        cycle(1'b1, 1'b1, 1'b0, 4'b1111, 36'h0_0000_0001); // R3 gate open, no select: read
        cycle(1'b1, 1'b1, 1'b1, 4'b0000, 36'hF_FFFF_FFFF); // R4 selects ignored
        cycle(1'b1, 1'b1, 1'b0, 4'b1110, 36'h8_0000_00FF); // R5 lane 0 alone
        cycle(1'b1, 1'b1, 1'b0, 4'b0111, 36'h8_FF00_0000); // R5 top lane and its parity
        cycle(1'b0, 1'b0, 1'b0, '0, 36'h7_7777_7777);    // R1 reset mid-write
        void'($urandom(32'd20240611));
        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] w;
            w = {$urandom(), $urandom()};
            cycle(($urandom() % 16) != 0, $urandom() % 4 == 0, $urandom() % 2 == 1,
                  L'($urandom()), w);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule